// File: doc/BRIEF.md
# PTP Seconds/Nanoseconds Time Counter

This block keeps a free-running time of day for precision time protocol use, held as a seconds count and a nanoseconds count. Every reference clock cycle it adds a programmable increment, given in nanoseconds with 32 integer and 32 fractional bits, to an accumulator. The upper half of the accumulator is the visible nanoseconds value and the lower half is a hidden fraction. When the sum reaches one billion nanoseconds, one billion is subtracted and the seconds count steps. The residual nanoseconds and fraction are kept, so no error builds up from one second to the next. Software trims the clock rate by rewriting the increment, and it can load a new time at any moment.

A capture strobe copies the seconds and nanoseconds into a holding pair in the same cycle, so both words belong to the same instant. A pulse-per-second output is produced by a three-state machine. `PPS_SYNC` holds the output low and waits for the next second boundary. `PPS_HIGH` drives the output high. `PPS_LOW` drives it low. The machine has these transitions:
- SYNC→HIGH on a second wrap.
- HIGH→HIGH (restart) on a wrap.
- HIGH→LOW when the elapsed time reaches the high duration.
- LOW→HIGH on a wrap, or when the elapsed time reaches the low duration.
- Any state→SYNC on a time load or on reset.

When a phase ends, the elapsed time carries the excess past the phase duration into the next phase.

Top module: `ptp_tod_counter`

## Requirements
- R1: Synchronous reset clears the seconds, nanoseconds, fraction and capture registers and puts the PPS machine in SYNC with the output low. It loads the increment with (10^9·2^32)/CLK_FREQ_HZ, which is 10.0 ns for the default 100 MHz. It loads both phase durations with 0x1DCD6500.00000000 (0.5 s).
- R2: Each cycle without a load, the 64-bit accumulator {nanoseconds[31:0], fraction[31:0]} grows by the 32.32 increment. Fraction carries appear in the nanoseconds.
- R3: The wrap happens only when the sum is at least 1,000,000,000 ns. A value of 999,999,999 (0x3B9AC9FF) is shown without a wrap.
- R4: On a wrap the accumulator becomes the sum minus 10^9·2^32, keeping the residual, and the seconds count steps by exactly one.
- R5: An increment written with `incr_wr` takes effect in the cycle after the strobe. The add in the strobe cycle uses the old increment.
- R6: `time_wr` loads seconds and nanoseconds (nanoseconds below 10^9) and clears the fraction. It takes priority over the add and any wrap in that cycle. It sends the PPS machine to SYNC, so the output is low after the load.
- R7: `capture` copies the pre-edge seconds and nanoseconds into `cap_sec`/`cap_ns`. These hold their value until the next capture.
- R8: The PPS output rises in the same cycle as the seconds count steps on a wrap.
- R9: In HIGH, the output falls once the elapsed time plus the increment reaches the high duration. In LOW, it rises once that sum reaches the low duration, or on a wrap. Any excess carries into the next phase.
- R10: The phase durations written with `pps_hi_wr`/`pps_lo_wr` (32.32 ns from `pps_wdata`) take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| incr_wr | input | 1 | Write strobe for the per-cycle increment |
| incr_wdata | input | 64 | New increment, 32.32 ns |
| pps_hi_wr | input | 1 | Write strobe for the high-phase duration |
| pps_lo_wr | input | 1 | Write strobe for the low-phase duration |
| pps_wdata | input | 64 | New phase duration, 32.32 ns |
| time_wr | input | 1 | Load strobe for the time of day |
| time_wsec | input | SEC_W | Seconds value to load |
| time_wns | input | 32 | Nanoseconds value to load |
| capture | input | 1 | Snapshot strobe |
| tod_sec | output | SEC_W | Live seconds count |
| tod_ns | output | 32 | Live nanoseconds count |
| cap_sec | output | SEC_W | Captured seconds |
| cap_ns | output | 32 | Captured nanoseconds |
| pps_out | output | 1 | Pulse-per-second output |

## Verification
Directed patterns target the boundaries:
- An integer increment stepped onto 999,999,999 and then onto exactly 10^9 separates a correct wrap from an early one or a reset-to-zero.
- A half-nanosecond increment shows whether fraction carries reach the visible count.
- A load placed where a wrap was due shows load priority.
- Short phase durations make every PPS transition visible within a few cycles.

A seeded random phase then mixes increments with random fractions, random durations whose sum differs from one second, random loads and random captures. This exercises residual carry, wrap-forced phase restarts and the timing of late writes against an independent model.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam logic [31:0] NS_PER_SEC       = 32'd1000000000;
    localparam logic [64:0] SEC_FIXED        = {1'b0, NS_PER_SEC, 32'd0};
    localparam logic [63:0] PPS_HALF_DEFAULT = {32'h1DCD6500, 32'd0};

    typedef enum logic [1:0] {
        PPS_SYNC = 2'd0,
        PPS_HIGH = 2'd1,
        PPS_LOW  = 2'd2
    } pps_state_e;

    // Nominal 32.32 nanoseconds per cycle for a given reference frequency.
    function automatic logic [63:0] nominal_incr(input longint unsigned freq_hz);
        longint unsigned num;
        num = 64'd1000000000 << 32;
        return 64'(num / freq_hz);
    endfunction

endpackage

// File: rtl/tod_rate_regs.sv
module tod_rate_regs
    import ptp_tod_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 100_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        incr_wr,
    input  logic [63:0] incr_wdata,
    input  logic        pps_hi_wr,
    input  logic        pps_lo_wr,
    input  logic [63:0] pps_wdata,
    output logic [63:0] incr_q,
    output logic [63:0] hi_dur_q,
    output logic [63:0] lo_dur_q
);

    localparam logic [63:0] INCR_RESET = nominal_incr(CLK_FREQ_HZ);

    always_ff @(posedge clk) begin
        if (rst) begin
            incr_q   <= INCR_RESET;
            hi_dur_q <= PPS_HALF_DEFAULT;
            lo_dur_q <= PPS_HALF_DEFAULT;
        end else begin
            if (incr_wr)   incr_q   <= incr_wdata;
            if (pps_hi_wr) hi_dur_q <= pps_wdata;
            if (pps_lo_wr) lo_dur_q <= pps_wdata;
        end
    end

    // R5: without a strobe the increment never moves
    a_r5_incr_hold: assert property (@(posedge clk) disable iff (rst)
        !incr_wr |=> $stable(incr_q));

    // R10: durations move only on their own strobes
    a_r10_hi_hold: assert property (@(posedge clk) disable iff (rst)
        !pps_hi_wr |=> $stable(hi_dur_q));

endmodule

// File: rtl/tod_accum.sv
module tod_accum
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [63:0]      incr_q,
    input  logic             load,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [31:0]      load_ns,
    output logic [SEC_W-1:0] tod_sec,
    output logic [31:0]      tod_ns,
    output logic             wrap_evt,
    output logic [63:0]      acc_next
);

    localparam int ACC_W = 64;

    logic [31:0]      frac_q;
    logic [ACC_W:0]   sum;
    logic             wrap;

    always_comb begin
        sum      = {1'b0, tod_ns, frac_q} + {1'b0, incr_q};
        wrap     = (sum >= SEC_FIXED);
        acc_next = wrap ? ACC_W'(sum - SEC_FIXED) : sum[ACC_W-1:0];
        wrap_evt = wrap && !load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_sec <= '0;
            tod_ns  <= '0;
            frac_q  <= '0;
        end else if (load) begin
            tod_sec <= load_sec;
            tod_ns  <= load_ns;
            frac_q  <= '0;
        end else begin
            {tod_ns, frac_q} <= acc_next;
            if (wrap) tod_sec <= tod_sec + SEC_W'(1);
        end
    end

    // R4: seconds move by zero or one per cycle when not loaded
    a_r4_sec_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst)) |->
        (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + SEC_W'(1)));

    // R4: after a wrap the residual is below one increment
    a_r4_residual: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst) && tod_sec != $past(tod_sec)) |->
        (tod_ns <= $past(incr_q[63:32])));

    // R2: within a second the nanoseconds never go backwards
    a_r2_forward: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst) && tod_sec == $past(tod_sec)) |->
        (tod_ns >= $past(tod_ns)));

endmodule

// File: rtl/tod_pps_fsm.sv
module tod_pps_fsm
    import ptp_tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] incr_q,
    input  logic [63:0] hi_dur_q,
    input  logic [63:0] lo_dur_q,
    input  logic        load,
    input  logic        wrap_evt,
    input  logic [63:0] acc_next,
    output logic        pps_out
);

    pps_state_e  state_q, state_n;
    logic [63:0] el_q, el_n;
    logic [64:0] el_sum;
    logic        hi_done, lo_done;

    always_comb begin
        el_sum  = {1'b0, el_q} + {1'b0, incr_q};
        hi_done = (el_sum >= {1'b0, hi_dur_q});
        lo_done = (el_sum >= {1'b0, lo_dur_q});
        state_n = state_q;
        el_n    = el_q;
        if (load) begin
            state_n = PPS_SYNC;
            el_n    = '0;
        end else if (wrap_evt) begin
            state_n = PPS_HIGH;
            el_n    = acc_next;
        end else begin
            unique case (state_q)
                PPS_SYNC: begin
                    state_n = PPS_SYNC;
                end
                PPS_HIGH: begin
                    if (hi_done) begin
                        state_n = PPS_LOW;
                        el_n    = 64'(el_sum - {1'b0, hi_dur_q});
                    end else begin
                        el_n    = el_sum[63:0];
                    end
                end
                PPS_LOW: begin
                    if (lo_done) begin
                        state_n = PPS_HIGH;
                        el_n    = 64'(el_sum - {1'b0, lo_dur_q});
                    end else begin
                        el_n    = el_sum[63:0];
                    end
                end
                default: begin
                    state_n = PPS_SYNC;
                    el_n    = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PPS_SYNC;
            el_q    <= '0;
        end else begin
            state_q <= state_n;
            el_q    <= el_n;
        end
    end

    always_comb begin
        pps_out = (state_q == PPS_HIGH);
    end

    // R8: a second wrap always leaves the output high
    a_r8_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> pps_out);

    // R6: a time load always leaves the output low
    a_r6_load_low: assert property (@(posedge clk) disable iff (rst)
        load |=> !pps_out);

    // R9: while waiting for sync nothing but a wrap can raise the output
    a_r9_sync_waits: assert property (@(posedge clk) disable iff (rst)
        (state_q == PPS_SYNC && !wrap_evt) |=> !pps_out);

endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot #(
    parameter int SEC_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [SEC_W-1:0] sec_in,
    input  logic [31:0]      ns_in,
    output logic [SEC_W-1:0] cap_sec,
    output logic [31:0]      cap_ns
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_sec <= '0;
            cap_ns  <= '0;
        end else if (capture) begin
            cap_sec <= sec_in;
            cap_ns  <= ns_in;
        end
    end

    // R7: the captured pair is frozen between strobes
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(cap_sec) && $stable(cap_ns)));

    // R7: a strobe takes the pre-edge nanoseconds
    a_r7_take: assert property (@(posedge clk) disable iff (rst)
        capture |=> (cap_ns == $past(ns_in)));

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
    parameter int              SEC_W       = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             incr_wr,
    input  logic [63:0]      incr_wdata,
    input  logic             pps_hi_wr,
    input  logic             pps_lo_wr,
    input  logic [63:0]      pps_wdata,
    input  logic             time_wr,
    input  logic [SEC_W-1:0] time_wsec,
    input  logic [31:0]      time_wns,
    input  logic             capture,
    output logic [SEC_W-1:0] tod_sec,
    output logic [31:0]      tod_ns,
    output logic [SEC_W-1:0] cap_sec,
    output logic [31:0]      cap_ns,
    output logic             pps_out
);

    logic [63:0] incr_q, hi_dur_q, lo_dur_q, acc_next;
    logic        wrap_evt;

    tod_rate_regs #(.CLK_FREQ_HZ(CLK_FREQ_HZ)) u_regs (
        .clk(clk), .rst(rst),
        .incr_wr(incr_wr), .incr_wdata(incr_wdata),
        .pps_hi_wr(pps_hi_wr), .pps_lo_wr(pps_lo_wr), .pps_wdata(pps_wdata),
        .incr_q(incr_q), .hi_dur_q(hi_dur_q), .lo_dur_q(lo_dur_q)
    );

    tod_accum #(.SEC_W(SEC_W)) u_accum (
        .clk(clk), .rst(rst), .incr_q(incr_q),
        .load(time_wr), .load_sec(time_wsec), .load_ns(time_wns),
        .tod_sec(tod_sec), .tod_ns(tod_ns),
        .wrap_evt(wrap_evt), .acc_next(acc_next)
    );

    tod_pps_fsm u_pps (
        .clk(clk), .rst(rst), .incr_q(incr_q),
        .hi_dur_q(hi_dur_q), .lo_dur_q(lo_dur_q),
        .load(time_wr), .wrap_evt(wrap_evt), .acc_next(acc_next),
        .pps_out(pps_out)
    );

    tod_snapshot #(.SEC_W(SEC_W)) u_snap (
        .clk(clk), .rst(rst), .capture(capture),
        .sec_in(tod_sec), .ns_in(tod_ns),
        .cap_sec(cap_sec), .cap_ns(cap_ns)
    );

endmodule

// File: tb/ptp_tod_counter_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_counter_tb_top;

    localparam int          SEC_W = 48;
    localparam logic [64:0] BIL   = {1'b0, 32'd1000000000, 32'd0};
    localparam logic [63:0] NOM   = 64'((64'd1000000000 << 32) / 64'd100000000);
    localparam logic [63:0] HALF  = {32'h1DCD6500, 32'd0};

    logic             clk = 1'b0;
    logic             rst;
    logic             incr_wr, pps_hi_wr, pps_lo_wr, time_wr, capture;
    logic [63:0]      incr_wdata, pps_wdata;
    logic [SEC_W-1:0] time_wsec;
    logic [31:0]      time_wns;
    logic [SEC_W-1:0] tod_sec, cap_sec;
    logic [31:0]      tod_ns, cap_ns;
    logic             pps_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // reference model state
    logic [SEC_W-1:0] m_sec, m_csec;
    logic [31:0]      m_cns;
    logic [63:0]      m_acc, m_incr, m_hi, m_lo, m_el;
    int               m_st;

    always #5 clk = ~clk;

    ptp_tod_counter dut_i (
        .clk(clk), .rst(rst),
        .incr_wr(incr_wr), .incr_wdata(incr_wdata),
        .pps_hi_wr(pps_hi_wr), .pps_lo_wr(pps_lo_wr), .pps_wdata(pps_wdata),
        .time_wr(time_wr), .time_wsec(time_wsec), .time_wns(time_wns),
        .capture(capture),
        .tod_sec(tod_sec), .tod_ns(tod_ns),
        .cap_sec(cap_sec), .cap_ns(cap_ns), .pps_out(pps_out)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [64:0] s, ps;
        logic [63:0] nxt;
        logic        wr;
        if (rst) begin
            m_sec = '0; m_acc = '0; m_incr = NOM; m_hi = HALF; m_lo = HALF;
            m_st = 0; m_el = '0; m_csec = '0; m_cns = '0;
            return;
        end
        if (capture) begin
            m_csec = m_sec;
            m_cns  = m_acc[63:32];
        end
        s   = {1'b0, m_acc} + {1'b0, m_incr};
        wr  = (s >= BIL);
        nxt = wr ? 64'(s - BIL) : s[63:0];
        ps  = {1'b0, m_el} + {1'b0, m_incr};
        if (time_wr) begin
            m_st = 0; m_el = '0;
        end else if (wr) begin
            m_st = 1; m_el = nxt;
        end else if (m_st == 1) begin
            if (ps >= {1'b0, m_hi}) begin m_st = 2; m_el = 64'(ps - {1'b0, m_hi}); end
            else m_el = ps[63:0];
        end else if (m_st == 2) begin
            if (ps >= {1'b0, m_lo}) begin m_st = 1; m_el = 64'(ps - {1'b0, m_lo}); end
            else m_el = ps[63:0];
        end
        if (time_wr) begin
            m_sec = time_wsec;
            m_acc = {time_wns, 32'd0};
        end else begin
            m_acc = nxt;
            if (wr) m_sec = m_sec + SEC_W'(1);
        end
        if (incr_wr)   m_incr = incr_wdata;
        if (pps_hi_wr) m_hi   = pps_wdata;
        if (pps_lo_wr) m_lo   = pps_wdata;
    endtask

    task automatic compare_all();
        chk(tod_sec == m_sec, "R4 seconds", 64'(tod_sec), 64'(m_sec));
        chk(tod_ns == m_acc[63:32], "R2 nanoseconds", 64'(tod_ns), 64'(m_acc[63:32]));
        chk(pps_out == (m_st == 1), "R9 pps", 64'(pps_out), 64'(m_st == 1));
        chk(cap_sec == m_csec, "R7 capture sec", 64'(cap_sec), 64'(m_csec));
        chk(cap_ns == m_cns, "R7 capture ns", 64'(cap_ns), 64'(m_cns));
    endtask

    task automatic cycle();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_strobes();
        incr_wr = 0; pps_hi_wr = 0; pps_lo_wr = 0; time_wr = 0; capture = 0;
    endtask

    task automatic load_time(input logic [SEC_W-1:0] s, input logic [31:0] ns);
        time_wr = 1; time_wsec = s; time_wns = ns;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [SEC_W-1:0] snap_s;
        logic [31:0]      snap_n;
        void'($urandom(32'd424242));
        rst = 1;
        clear_strobes();
        incr_wdata = '0; pps_wdata = '0; time_wsec = '0; time_wns = '0;
        repeat (3) cycle();
        // R1: reset state
        chk(tod_sec == 0 && tod_ns == 0 && !pps_out && cap_ns == 0,
            "R1 reset state", 64'(tod_ns), 64'd0);
        rst = 0;
        repeat (5) cycle();
        chk(tod_ns == 32'd50, "R1 default increment 10 ns", 64'(tod_ns), 64'd50);

        // R3/R4: no early wrap, exact wrap with residual
        load_time(48'd7, 32'd999999989); cycle(); clear_strobes();
        chk(tod_ns == 32'd999999989, "R6 load value", 64'(tod_ns), 64'd999999989);
        cycle();
        chk(tod_ns == 32'h3B9AC9FF && tod_sec == 48'd7, "R3 no early wrap",
            64'(tod_ns), 64'h3B9AC9FF);
        cycle();
        chk(tod_ns == 32'd9 && tod_sec == 48'd8, "R4 wrap residual",
            64'(tod_ns), 64'd9);

        // R6: load wins over a due wrap
        load_time(48'd2, 32'd999999995); cycle(); clear_strobes();
        load_time(48'd3, 32'd5); cycle(); clear_strobes();
        chk(tod_sec == 48'd3 && tod_ns == 32'd5 && !pps_out, "R6 load priority",
            64'(tod_sec), 64'd3);

        // R5/R2: late increment write and fraction carry
        load_time(48'd0, 32'd100); cycle(); clear_strobes();
        incr_wr = 1; incr_wdata = {32'd10, 32'h8000_0000}; cycle(); clear_strobes();
        chk(tod_ns == 32'd110, "R5 old increment in write cycle", 64'(tod_ns), 64'd110);
        cycle();
        chk(tod_ns == 32'd120, "R5 new increment", 64'(tod_ns), 64'd120);
        cycle();
        chk(tod_ns == 32'd131, "R2 fraction carry", 64'(tod_ns), 64'd131);
        cycle();
        chk(tod_ns == 32'd141, "R2 fraction carry", 64'(tod_ns), 64'd141);

        // R8/R10: short high phase aligned to the second
        incr_wr = 1; incr_wdata = {32'd10, 32'd0};
        pps_hi_wr = 1; pps_wdata = {32'd30, 32'd0};
        load_time(48'd20, 32'd999999970); cycle(); clear_strobes();
        pps_lo_wr = 1; pps_wdata = {32'd999999970, 32'd0}; cycle(); clear_strobes();
        chk(tod_ns == 32'd980 + 32'd999999000, "R2 step", 64'(tod_ns), 64'd999999980);
        cycle();
        chk(!pps_out, "R6 output low before wrap", 64'(pps_out), 64'd0);
        cycle();
        chk(pps_out && tod_sec == 48'd21 && tod_ns == 0, "R8 rise with wrap",
            64'(pps_out), 64'd1);
        cycle(); cycle();
        chk(pps_out, "R10 still high at 20 ns", 64'(pps_out), 64'd1);
        cycle();
        chk(!pps_out, "R10 high duration ends at 30 ns", 64'(pps_out), 64'd0);

        // R9: low phase ends by its own duration
        incr_wr = 1; incr_wdata = {32'd10000000, 32'd0};
        pps_hi_wr = 1; pps_lo_wr = 1; pps_wdata = {32'd30000000, 32'd0};
        load_time(48'd5, 32'd990000000); cycle(); clear_strobes();
        cycle();
        chk(pps_out, "R8 rise on wrap", 64'(pps_out), 64'd1);
        cycle(); cycle(); cycle();
        chk(!pps_out, "R9 fall after high duration", 64'(pps_out), 64'd0);
        cycle(); cycle(); cycle();
        chk(pps_out, "R9 rise after low duration", 64'(pps_out), 64'd1);

        // R7: capture of the pre-edge pair
        snap_s = tod_sec; snap_n = tod_ns;
        capture = 1; cycle(); clear_strobes();
        chk(cap_sec == snap_s && cap_ns == snap_n, "R7 coherent capture",
            64'(cap_ns), 64'(snap_n));
        cycle();
        chk(cap_ns == snap_n, "R7 capture holds", 64'(cap_ns), 64'(snap_n));

        // random mix checked against the model every cycle
        incr_wr = 1; incr_wdata = {32'd15000000, 32'd0}; cycle(); clear_strobes();
        for (int i = 0; i < 3000; i++) begin
            incr_wr    = ($urandom % 16) == 0;
            incr_wdata = {32'd1000000 + ($urandom % 32'd29000000), $urandom};
            pps_hi_wr  = ($urandom % 40) == 0;
            pps_lo_wr  = ($urandom % 40) == 0;
            pps_wdata  = {32'd50000000 + ($urandom % 32'd550000000), $urandom};
            time_wr    = ($urandom % 200) == 0;
            time_wsec  = SEC_W'({$urandom, $urandom});
            time_wns   = $urandom % 32'd1000000000;
            capture    = ($urandom % 5) == 0;
            cycle();
        end
        clear_strobes();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule